// File: doc/BRIEF.md
# UART Receive Holding Stage with DMA Request

This block sits behind the bit-level receiver of a UART and keeps the bytes that the receiver has finished deserialising until a bus master or a DMA engine collects them. Each incoming byte arrives on a one-cycle valid strobe together with its framing-error and noise indications. The byte is kept either in a single holding slot or, when queue mode is selected, in an eight-entry first-in-first-out store. A single read strobe, used by software or by a DMA engine, removes the oldest byte. The head byte is always visible on the read data port.

A not-empty indication drives a data interrupt in software-driven operation. When DMA reception is enabled, it drives a DMA request instead. In both modes the request follows whichever storage is active, the single slot or the queue. Framing, noise and overrun conditions are kept in sticky flags and feed an error interrupt that is separate from the data interrupt. Software clears each flag by writing one to its clear bit. In DMA mode the framing and noise flags of a byte are raised only once that byte has been taken, which ties the error to the transfer just completed.

Top module: `uart_rx_holding`

## Requirements
- R1: With queue mode off, a byte strobed into an empty stage makes `not_empty_o` high on the cycle after the strobe, and `rd_data_o` then shows that byte.
- R2: A cycle with `rd_i` high while the stage holds data removes the oldest byte. When that was the last byte, `not_empty_o` is low from the next cycle on. A read while empty changes nothing.
- R3: With queue mode on, up to 8 bytes are held and are read out in arrival order.
- R4: A byte that arrives while the stage is full (1 byte with queue mode off, 8 with it on) and no read occurs in the same cycle is discarded, and the overrun flag is set. A byte that arrives in the same cycle as a read of a full stage is accepted.
- R5: `dma_req_o` is high exactly when `dma_en_i` is high and the stage holds data, in either storage mode.
- R6: `data_irq_o` is high exactly when `data_ie_i` is high, `dma_en_i` is low and the stage holds data.
- R7: With DMA off, a byte strobed with its framing or noise indication sets the matching flag on the same cycle that `not_empty_o` rises.
- R8: With DMA on, a byte's framing or noise indication is stored with the byte. The matching flag is set on the cycle after the read that removes that byte, and not before.
- R9: `fe_o`, `nf_o` and `ore_o` are sticky and reading data does not clear them. `clr_i` bit 0 clears framing, bit 1 clears noise and bit 2 clears overrun. A set in the same cycle as a clear wins.
- R10: `err_irq_o` is high exactly when `err_ie_i` is high and at least one of the three error flags is set.
- R11: After reset the stage is empty, all flags are clear, and `dma_req_o`, `data_irq_o` and `err_irq_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_valid_i | input | 1 | One-cycle strobe: a received byte is present |
| rx_data_i | input | DW | Received byte |
| rx_ferr_i | input | 1 | Framing error indication for this byte |
| rx_nerr_i | input | 1 | Noise indication for this byte |
| fifo_en_i | input | 1 | Queue mode select (1 = 8-entry queue, 0 = single slot) |
| dma_en_i | input | 1 | DMA reception enable |
| data_ie_i | input | 1 | Data interrupt enable |
| err_ie_i | input | 1 | Error interrupt enable |
| rd_i | input | 1 | Read strobe from software or DMA; removes the head byte |
| clr_i | input | 3 | Write-one-to-clear: bit 0 framing, bit 1 noise, bit 2 overrun |
| rd_data_o | output | DW | Oldest held byte |
| not_empty_o | output | 1 | Stage holds at least one byte |
| dma_req_o | output | 1 | DMA request |
| data_irq_o | output | 1 | Data interrupt |
| err_irq_o | output | 1 | Error interrupt |
| fe_o | output | 1 | Sticky framing error flag |
| nf_o | output | 1 | Sticky noise flag |
| ore_o | output | 1 | Sticky overrun flag |

## Verification
A corrupted occupancy count or pointer appears at the ports as a wrong byte on `rd_data_o`, a `not_empty_o` that stays up or drops early, or an overrun at the wrong fill level. The scoreboard catches each of these at the next read or the next arrival. An error bit stored with the wrong entry shows in DMA mode as a framing or noise flag that rises one read too early or too late. This is visible on the cycle after that read. Flag or gating faults show on the interrupt and request lines on the very next sample after the triggering edge.

// File: rtl/uart_rxh_pkg.sv
package uart_rxh_pkg;

    typedef struct packed {
        logic ore;
        logic nf;
        logic fe;
    } err_flags_t;

    localparam int unsigned CLR_FE  = 0;
    localparam int unsigned CLR_NF  = 1;
    localparam int unsigned CLR_ORE = 2;
    localparam int unsigned CLR_W   = 3;

endpackage

// File: rtl/rxh_store.sv
module rxh_store #(
    parameter int unsigned EW    = 10,
    parameter int unsigned DEPTH = 8
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         push_i,
    input  logic                         pop_i,
    input  logic [EW-1:0]                wr_entry_i,
    output logic [EW-1:0]                head_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][EW-1:0] mem;
        logic [PW-1:0]            wp;
        logic [PW-1:0]            rp;
        logic [CW-1:0]            cnt;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (push_i) begin
            s_d.mem[s_q.wp] = wr_entry_i;
            s_d.wp = (s_q.wp == LAST) ? '0 : s_q.wp + PW'(1);
        end
        if (pop_i) begin
            s_d.rp = (s_q.rp == LAST) ? '0 : s_q.rp + PW'(1);
        end
        unique case ({push_i, pop_i})
            2'b10:   s_d.cnt = s_q.cnt + CW'(1);
            2'b01:   s_d.cnt = s_q.cnt - CW'(1);
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign head_o  = s_q.mem[s_q.rp];
    assign count_o = s_q.cnt;

endmodule

// File: rtl/rxh_errflags.sv
module rxh_errflags
    import uart_rxh_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              dma_mode_i,
    input  logic              arr_take_i,
    input  logic              arr_fe_i,
    input  logic              arr_nf_i,
    input  logic              pop_take_i,
    input  logic              head_fe_i,
    input  logic              head_nf_i,
    input  logic              ovr_i,
    input  logic [CLR_W-1:0]  clr_i,
    output err_flags_t        flags_o
);
    err_flags_t f_d, f_q;
    logic set_fe, set_nf;

    always_comb begin
        set_fe = (!dma_mode_i && arr_take_i && arr_fe_i) ||
                 ( dma_mode_i && pop_take_i && head_fe_i);
        set_nf = (!dma_mode_i && arr_take_i && arr_nf_i) ||
                 ( dma_mode_i && pop_take_i && head_nf_i);
        f_d.fe  = set_fe || (f_q.fe  && !clr_i[CLR_FE]);
        f_d.nf  = set_nf || (f_q.nf  && !clr_i[CLR_NF]);
        f_d.ore = ovr_i  || (f_q.ore && !clr_i[CLR_ORE]);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) f_q <= '0;
        else         f_q <= f_d;
    end

    assign flags_o = f_q;

endmodule

// File: rtl/uart_rx_holding.sv
module uart_rx_holding
    import uart_rxh_pkg::*;
#(
    parameter int unsigned DW    = 8,
    parameter int unsigned DEPTH = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rx_valid_i,
    input  logic [DW-1:0]     rx_data_i,
    input  logic              rx_ferr_i,
    input  logic              rx_nerr_i,
    input  logic              fifo_en_i,
    input  logic              dma_en_i,
    input  logic              data_ie_i,
    input  logic              err_ie_i,
    input  logic              rd_i,
    input  logic [CLR_W-1:0]  clr_i,
    output logic [DW-1:0]     rd_data_o,
    output logic              not_empty_o,
    output logic              dma_req_o,
    output logic              data_irq_o,
    output logic              err_irq_o,
    output logic              fe_o,
    output logic              nf_o,
    output logic              ore_o
);
    localparam int unsigned EW = DW + 2;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CAP_QUEUE  = CW'(DEPTH);
    localparam logic [CW-1:0] CAP_SINGLE = CW'(1);

    logic [EW-1:0] wr_entry, head;
    logic [CW-1:0] occ;
    logic          has_data, at_cap, pop_take, arr_take, ovr;
    err_flags_t    flags;

    always_comb begin
        has_data = (occ != '0);
        at_cap   = occ >= (fifo_en_i ? CAP_QUEUE : CAP_SINGLE);
        pop_take = rd_i && has_data;
        arr_take = rx_valid_i && (!at_cap || pop_take);
        ovr      = rx_valid_i && at_cap && !pop_take;
        wr_entry = {rx_nerr_i, rx_ferr_i, rx_data_i};
    end

    rxh_store #(.EW(EW), .DEPTH(DEPTH)) store_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .push_i     (arr_take),
        .pop_i      (pop_take),
        .wr_entry_i (wr_entry),
        .head_o     (head),
        .count_o    (occ)
    );

    rxh_errflags flags_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .dma_mode_i (dma_en_i),
        .arr_take_i (arr_take),
        .arr_fe_i   (rx_ferr_i),
        .arr_nf_i   (rx_nerr_i),
        .pop_take_i (pop_take),
        .head_fe_i  (head[DW]),
        .head_nf_i  (head[DW+1]),
        .ovr_i      (ovr),
        .clr_i      (clr_i),
        .flags_o    (flags)
    );

    assign rd_data_o   = head[DW-1:0];
    assign not_empty_o = has_data;
    assign dma_req_o   = dma_en_i && has_data;
    assign data_irq_o  = data_ie_i && !dma_en_i && has_data;
    assign fe_o        = flags.fe;
    assign nf_o        = flags.nf;
    assign ore_o       = flags.ore;
    assign err_irq_o   = err_ie_i && (flags.fe || flags.nf || flags.ore);

endmodule

// File: rtl/uart_rx_holding_chk.sv
module uart_rx_holding_chk #(
    parameter int unsigned DEPTH = 8
) (
    input logic                       clk_i,
    input logic                       rst_ni,
    input logic                       rx_valid_i,
    input logic                       rd_i,
    input logic                       fifo_en_i,
    input logic                       dma_en_i,
    input logic                       err_ie_i,
    input logic [2:0]                 clr_i,
    input logic                       not_empty_o,
    input logic                       dma_req_o,
    input logic                       err_irq_o,
    input logic                       ore_o,
    input logic [$clog2(DEPTH+1)-1:0] occ
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    a_r1_arrival_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_valid_i && !rd_i && occ == '0) |=> not_empty_o);

    a_r2_last_pop_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && !rx_valid_i && occ == CW'(1)) |=> !not_empty_o);

    a_r3_occ_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
        occ <= CW'(DEPTH));

    a_r4_single_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_valid_i && !fifo_en_i && not_empty_o && !rd_i) |=> ore_o);

    a_r5_dma_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dma_en_i |-> !dma_req_o);

    a_r5_dma_needs_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dma_req_o |-> not_empty_o);

    a_r9_ore_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ore_o && !clr_i[2]) |=> ore_o);

    a_r10_err_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !err_ie_i |-> !err_irq_o);

endmodule

bind uart_rx_holding uart_rx_holding_chk #(.DEPTH(DEPTH)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_valid_i  (rx_valid_i),
    .rd_i        (rd_i),
    .fifo_en_i   (fifo_en_i),
    .dma_en_i    (dma_en_i),
    .err_ie_i    (err_ie_i),
    .clr_i       (clr_i),
    .not_empty_o (not_empty_o),
    .dma_req_o   (dma_req_o),
    .err_irq_o   (err_irq_o),
    .ore_o       (ore_o),
    .occ         (occ)
);

// File: tb/uart_rx_holding_tb_top.sv
`timescale 1ns/1ps
module uart_rx_holding_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_ferr = 1'b0, rx_nerr = 1'b0;
    logic       fifo_en = 1'b0, dma_en = 1'b0, data_ie = 1'b0, err_ie = 1'b0;
    logic       rd = 1'b0;
    logic [2:0] clr = '0;
    logic [7:0] rd_data;
    logic       not_empty, dma_req, data_irq, err_irq, fe, nf, ore;

    int n_tests = 0;
    int n_fail  = 0;
    int model_cnt = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;

    uart_rx_holding dut_i (
        .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
        .rx_ferr_i(rx_ferr), .rx_nerr_i(rx_nerr), .fifo_en_i(fifo_en),
        .dma_en_i(dma_en), .data_ie_i(data_ie), .err_ie_i(err_ie), .rd_i(rd),
        .clr_i(clr), .rd_data_o(rd_data), .not_empty_o(not_empty),
        .dma_req_o(dma_req), .data_irq_o(data_irq), .err_irq_o(err_irq),
        .fe_o(fe), .nf_o(nf), .ore_o(ore)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One clock of stimulus, entered and left at a falling edge.
    // Scoreboard: accepted bytes are queued; every read pops and compares.
    task automatic cyc(input logic v, input logic [7:0] d, input logic f,
                       input logic n, input logic r, input logic [2:0] c,
                       input string req);
        int  cap;
        bit  pop_ok, acc;
        cap    = fifo_en ? 8 : 1;
        pop_ok = r && (model_cnt > 0);
        acc    = v && ((model_cnt < cap) || pop_ok);
        if (pop_ok) chk(req, "read data", {24'h0, rd_data}, {24'h0, exp_q.pop_front()});
        rx_valid = v; rx_data = d; rx_ferr = f; rx_nerr = n; rd = r; clr = c;
        @(negedge clk);
        rx_valid = 1'b0; rx_ferr = 1'b0; rx_nerr = 1'b0; rd = 1'b0; clr = '0;
        if (pop_ok) model_cnt--;
        if (acc) begin
            model_cnt++;
            exp_q.push_back(d);
        end
    endtask

    task automatic put(input logic [7:0] d, input string req);
        cyc(1'b1, d, 1'b0, 1'b0, 1'b0, 3'b000, req);
    endtask

    task automatic take(input string req);
        cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 3'b000, req);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        data_ie = 1'b1; err_ie = 1'b1;
        #1;
        // R11 reset state
        chk("R11", "not_empty", {31'h0, not_empty}, 0);
        chk("R11", "flags", {29'h0, ore, nf, fe}, 0);
        chk("R11", "irqs/req", {29'h0, dma_req, data_irq, err_irq}, 0);
        @(negedge clk);

        // R1 single slot fill, R6 data interrupt
        put(8'hA5, "R1");
        chk("R1", "not_empty", {31'h0, not_empty}, 1);
        chk("R1", "head", {24'h0, rd_data}, 32'hA5);
        chk("R6", "data_irq", {31'h0, data_irq}, 1);
        // R4 overrun on full single slot, R10 error irq
        put(8'h3C, "R4");
        chk("R4", "ore", {31'h0, ore}, 1);
        chk("R10", "err_irq", {31'h0, err_irq}, 1);
        chk("R4", "head kept", {24'h0, rd_data}, 32'hA5);
        take("R4");
        chk("R2", "not_empty after last", {31'h0, not_empty}, 0);
        chk("R9", "ore survives read", {31'h0, ore}, 1);
        cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 3'b100, "R9");
        chk("R9", "ore cleared", {31'h0, ore}, 0);
        chk("R10", "err_irq low", {31'h0, err_irq}, 0);

        // R4 arrival together with read of a full slot is accepted
        put(8'h11, "R4");
        cyc(1'b1, 8'h22, 1'b0, 1'b0, 1'b1, 3'b000, "R4");
        chk("R4", "no overrun", {31'h0, ore}, 0);
        chk("R4", "new head", {24'h0, rd_data}, 32'h22);
        take("R4");

        // R2 read while empty does nothing
        take("R2");
        chk("R2", "still empty", {31'h0, not_empty}, 0);
        put(8'h33, "R2");
        chk("R2", "head after empty read", {24'h0, rd_data}, 32'h33);
        take("R2");

        // R3 queue mode fill, R4 overflow at 8
        fifo_en = 1'b1;
        for (int i = 0; i < 8; i++) put(8'(i * 17 + 1), "R3");
        chk("R3", "ore before full", {31'h0, ore}, 0);
        put(8'hEE, "R4");
        chk("R4", "queue overrun", {31'h0, ore}, 1);
        for (int i = 0; i < 7; i++) take("R3");
        chk("R3", "one left", {31'h0, not_empty}, 1);
        take("R3");
        chk("R2", "queue drained", {31'h0, not_empty}, 0);
        cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 3'b111, "R9");

        // R5 DMA request and R6 data irq suppressed in DMA mode
        dma_en = 1'b1;
        #1;
        chk("R5", "dma_req empty", {31'h0, dma_req}, 0);
        @(negedge clk);
        put(8'h5A, "R5");
        chk("R5", "dma_req", {31'h0, dma_req}, 1);
        chk("R6", "data_irq in dma", {31'h0, data_irq}, 0);
        put(8'h6B, "R5");
        take("R5");
        chk("R5", "dma_req still", {31'h0, dma_req}, 1);
        take("R5");
        chk("R5", "dma_req after drain", {31'h0, dma_req}, 0);

        // R8 DMA mode: noise flag only after the byte is taken
        put(8'h77, "R8");
        put(8'h78, "R8");
        cyc(1'b1, 8'h79, 1'b0, 1'b1, 1'b0, 3'b000, "R8");
        chk("R8", "nf not yet", {31'h0, nf}, 0);
        take("R8");
        take("R8");
        chk("R8", "nf before flagged read", {31'h0, nf}, 0);
        take("R8");
        chk("R8", "nf after read", {31'h0, nf}, 1);
        chk("R10", "err_irq nf", {31'h0, err_irq}, 1);
        cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 3'b010, "R9");
        chk("R9", "nf cleared", {31'h0, nf}, 0);

        // R7 non-DMA: framing flag with not_empty; R9 set wins over clear
        dma_en = 1'b0; fifo_en = 1'b0;
        @(negedge clk);
        cyc(1'b1, 8'h90, 1'b1, 1'b0, 1'b0, 3'b001, "R7");
        chk("R7", "fe with byte", {31'h0, fe}, 1);
        chk("R7", "not_empty", {31'h0, not_empty}, 1);
        take("R9");
        chk("R9", "fe survives read", {31'h0, fe}, 1);
        err_ie = 1'b0;
        #1;
        chk("R10", "err_irq masked", {31'h0, err_irq}, 0);
        @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule